// File: doc/BRIEF.md
# Delay-Length Code Loader with Serial and Parallel Sources

This block gives a delay-line core its 11-bit delay-length code. The code can come from two places, chosen by a mode input. In parallel mode, eleven code pins are registered on every main-clock edge. In serial mode, a bit stream is shifted in on its own shift clock, most significant bit first. A latch strobe then copies the whole 11-bit word into a holding register in one step.

The shift clock and strobe have no fixed relation to the main clock. The holding register is written only on the strobe's rising edge. The strobe itself is passed through a reset-initialised synchroniser into the main clock domain. Its synchronised rising edge copies the holding register into the code the core uses. The holding register is stable by then, so the core never takes a word that is only partly updated.

Alongside the code, the block gives the effective delay length, which is the code plus a fixed base of 31 samples. The block assumes the strobe stays high, and then low, for at least three main-clock cycles each time. It also assumes the shift clock is idle while the strobe rises.

Top module: `dlc_cfg_loader`

## Requirements
- R1: While `rst_n` is low at a `clk` rising edge, `code_o` is 0 and `delay_len_o` is 31 after that edge.
- R2: Each rising edge of `shift_clk` shifts `shift_din` into bit 0 of the shift register and moves every bit up by one place. After eleven edges, the first bit sent is at bit 10 of the word and the last bit sent is at bit 0. If more than eleven bits are sent, only the last eleven are kept.
- R3: The rising edge of `latch_stb` copies all 11 shift-register bits into the holding register at once. `shift_clk` edges after that copy do not change the delivered code until the next strobe edge.
- R4: Suppose `latch_stb` is first seen high at main-clock edge n and was low at edge n-1, and `mode_par` is low at edge n+2. Then `code_o` takes the held word at edge n+2.
- R5: With `mode_par` low, `code_o` changes only through R4. Changes on `code_pins` have no effect.
- R6: With `mode_par` high at a `clk` edge, `code_o` takes the value on `code_pins` at that edge.
- R7: If `mode_par` is high at the edge where a strobe would be taken (edge n+2 in R4), that strobe is discarded. It is not applied later.
- R8: When `mode_par` goes from high to low, `code_o` keeps the last parallel value until a strobe is taken.
- R9: `delay_len_o` always equals `code_o` + 31, so it ranges from 31 to 2078.
- R10: If `latch_stb` is already high when `rst_n` is released, no code is taken from that strobe level. `code_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sample clock |
| rst_n | input | 1 | Synchronous active-low reset, main domain |
| mode_par | input | 1 | 1 selects the parallel pins, 0 selects the serial path |
| code_pins | input | 11 | Parallel delay-length code |
| shift_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| shift_din | input | 1 | Serial data, MSB first |
| latch_stb | input | 1 | Rising edge copies the shifted word into the holding register |
| code_o | output | 11 | Delay-length code presented to the core |
| delay_len_o | output | 12 | Effective delay length, code plus 31 |

## Verification
A synchronised strobe edge can reach the main domain in the same cycle that the mode input switches. The bench provokes this by raising the strobe and then lowering `mode_par` either two or three falling clock edges later. The first case puts the serial take into the first serial cycle, so the word must be delivered (R4). The second case lands the take on the last parallel cycle, so the word must be lost and the parallel value kept (R7, R8). A queue-based reference model follows both cases on every cycle.

// File: rtl/dlc_pkg.sv
// Shared constants, types and the code-to-length mapping for the
// delay-length loader. Assumes an unsigned binary code.
package dlc_pkg;
    localparam int CODE_W     = 11;
    localparam int LEN_W      = CODE_W + 1;
    localparam int LEN_BASE   = 31;
    localparam int SYNC_DEPTH = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  dlen_t;

    // Effective delay length for a given code.
    function automatic dlen_t code_to_len(input code_t c);
        return LEN_W'(c) + LEN_W'(LEN_BASE);
    endfunction
endpackage

// File: rtl/dlc_shift_capture.sv
// Serial side of the loader. The shift register runs on the shift clock,
// MSB first. The holding register is loaded on the rising edge of the strobe.
// Assumes the shift clock is idle while the strobe rises. Holds data only,
// so it has no reset.
module dlc_shift_capture #(
    parameter int W = 11
) (
    input  logic         shift_clk,
    input  logic         shift_din,
    input  logic         latch_stb,
    output logic [W-1:0] held
);
    logic [W-1:0] sreg;

    // Shift one bit in at bit 0. Older bits move toward the MSB.
    always_ff @(posedge shift_clk) begin
        sreg <= {sreg[W-2:0], shift_din};
    end

    // Copy the whole word in one step on the strobe edge.
    always_ff @(posedge latch_stb) begin
        held <= sreg;
    end
endmodule

// File: rtl/dlc_sync_bit.sv
// Multi-flop synchroniser for one level signal. Reset loads RST_VAL into
// every stage. Assumes the input is a slow level held for several cycles.
module dlc_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // Move the sample through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dlc_cfg_loader.sv
// Top level of the delay-length loader. It picks the parallel pins or the
// serially loaded word and delivers the code in the main clock domain.
// The strobe level is synchronised, and its rising edge in the clk domain
// takes the holding register. The holding register is stable by then.
// Assumes the strobe stays high, and then low, for at least SYNC_DEPTH+1
// clk cycles each time.
module dlc_cfg_loader
    import dlc_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_par,
    input  logic [10:0] code_pins,
    input  logic        shift_clk,
    input  logic        shift_din,
    input  logic        latch_stb,
    output logic [10:0] code_o,
    output logic [11:0] delay_len_o
);
    code_t held_code;
    logic  stb_sync;
    logic  stb_prev;
    logic  ser_take;
    code_t code_q;

    dlc_shift_capture #(.W(CODE_W)) u_cap (
        .shift_clk (shift_clk),
        .shift_din (shift_din),
        .latch_stb (latch_stb),
        .held      (held_code)
    );

    // Reset value 1, so a strobe already high at reset release is not taken.
    dlc_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (latch_stb),
        .q     (stb_sync)
    );

    // Keep the previous synchronised level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b1;
        else        stb_prev <= stb_sync;
    end

    assign ser_take = stb_sync & ~stb_prev;

    // Choose the code source: parallel pins, a serial take, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        code_q <= '0;
        else if (mode_par) code_q <= code_pins;
        else if (ser_take) code_q <= held_code;
    end

    assign code_o      = code_q;
    assign delay_len_o = code_to_len(code_q);
endmodule

// File: rtl/dlc_cfg_loader_chk.sv
// Checker for dlc_cfg_loader, attached with bind. It observes the ports,
// the take pulse and the holding register.
module dlc_cfg_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_par,
    input logic [10:0] code_pins,
    input logic        take,
    input logic [10:0] held,
    input logic [10:0] code_o
);
    bit armed   = 1'b0;
    bit rst_seen = 1'b1;

    // After a clock edge with reset low, the code must read 0.
    always_ff @(posedge clk) begin
        armed    <= 1'b1;
        rst_seen <= rst_n;
        if (armed && !rst_seen)
            AST_RESET_ZERO: assert (code_o == 11'd0) else $error("reset code"); // R1
    end

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_par |=> code_o == $past(code_pins)); // R6

    AST_SER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && take) |=> code_o == $past(held)); // R4

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_par && !take) |=> $stable(code_o)); // R5
endmodule

bind dlc_cfg_loader dlc_cfg_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_par  (mode_par),
    .code_pins (code_pins),
    .take      (ser_take),
    .held      (held_code),
    .code_o    (code_o)
);

// File: tb/tb_dlc_cfg_loader.sv
`timescale 1ns/1ps
module tb_dlc_cfg_loader;
    localparam real CLK_P = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_par = 1'b0;
    logic [10:0] code_pins = 11'h555;
    logic        shift_clk = 1'b0;
    logic        shift_din = 1'b0;
    logic        latch_stb = 1'b0;
    logic [10:0] code_o;
    logic [11:0] delay_len_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // Reference model state
    logic [10:0] shadow = '0;
    logic [10:0] exp_hold = '0;
    logic [10:0] exp_code = '0;
    bit          lq[$];
    string       tag = "R1";
    logic [31:0] seed = 32'h1234_5678;

    dlc_cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .code_pins(code_pins),
        .shift_clk(shift_clk), .shift_din(shift_din), .latch_stb(latch_stb),
        .code_o(code_o), .delay_len_o(delay_len_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural model: strobe history queue and source selection.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_code = '0;
            lq = '{1'b1, 1'b1, 1'b1, 1'b1};
            tag = "R1";
            cmp_on = 1'b1;
        end else begin
            lq.push_front(latch_stb);
            if (lq.size() > 6) void'(lq.pop_back());
            if (mode_par) begin
                exp_code = code_pins; tag = "R6";
            end else if (lq[2] && !lq[3]) begin
                exp_code = exp_hold; tag = "R4";
            end else begin
                tag = "R5";
            end
        end
    end

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_vec++;
            if (code_o !== exp_code) begin
                n_bad++;
                $display("FAIL %s code_o actual %h expected %h", tag, code_o, exp_code);
            end
            n_vec++;
            if (delay_len_o !== 12'(exp_code) + 12'd31) begin
                n_bad++;
                $display("FAIL R9 delay_len_o actual %0d expected %0d",
                         delay_len_o, 12'(exp_code) + 12'd31);
            end
        end
    end

    task automatic check_now(input string req, input logic [10:0] want);
        n_vec++;
        if (code_o !== want) begin
            n_bad++;
            $display("FAIL %s code_o actual %h expected %h", req, code_o, want);
        end
    endtask

    task automatic check_len(input string req, input logic [11:0] want);
        n_vec++;
        if (delay_len_o !== want) begin
            n_bad++;
            $display("FAIL %s delay_len_o actual %0d expected %0d", req, delay_len_o, want);
        end
    endtask

    // Send nb bits of w, MSB first, on the unrelated shift clock.
    task automatic shift_bits(input logic [15:0] w, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            shift_din = w[i];
            #3.7 shift_clk = 1'b1;
            shadow = {shadow[9:0], w[i]};
            #4.1 shift_clk = 1'b0;
        end
        #2.3;
    endtask

    // Pulse the strobe. Lower mode_par k falling edges after the rise (k=0: leave it).
    task automatic pulse_stb(input int k);
        @(negedge clk); #1;
        latch_stb = 1'b1;
        exp_hold = shadow;
        if (k > 0) begin
            repeat (k) @(negedge clk);
            #1 mode_par = 1'b0;
            repeat (5 - k) @(negedge clk);
        end else begin
            repeat (5) @(negedge clk);
        end
        #1 latch_stb = 1'b0;
        repeat (5) @(negedge clk);
        #1;
    endtask

    task automatic load_serial(input logic [10:0] w);
        shift_bits({5'd0, w}, 11);
        pulse_stb(0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1", 11'd0);
        check_len("R1", 12'd31);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R9: MSB-first word 0x1E2 gives length 513
        load_serial(11'h1E2);
        check_now("R2", 11'h1E2);
        check_len("R9", 12'd513);

        // R2: extra leading bits are pushed out, only the last 11 kept
        shift_bits(16'hA7FF, 16);
        pulse_stb(0);
        check_now("R2", 11'h7FF);
        check_len("R9", 12'd2078);

        // R3: shifting without a strobe does not change the code
        shift_bits(16'h0123, 11);
        repeat (4) @(negedge clk);
        check_now("R3", 11'h7FF);
        pulse_stb(0);
        check_now("R3", 11'h123);

        // R5: parallel pins are ignored in serial mode
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1 code_pins = 11'(i * 301 + 7);
        end
        @(negedge clk);
        check_now("R5", 11'h123);

        // Several serial codes, including the extremes
        load_serial(11'h000);
        check_now("R4", 11'h000);
        check_len("R9", 12'd31);
        load_serial(11'h3E1);
        check_now("R4", 11'h3E1);
        load_serial(11'h2AA);
        check_now("R4", 11'h2AA);

        // R6: parallel mode follows the pins each cycle
        @(negedge clk); #1 mode_par = 1'b1;
        for (int i = 0; i < 20; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            @(negedge clk); #1 code_pins = seed[26:16];
        end
        @(negedge clk); #1 code_pins = 11'h4C3;
        @(negedge clk);
        check_now("R6", 11'h4C3);

        // R7/R8: the take falls on the last parallel cycle and is lost
        shift_bits(16'h0615, 11);
        pulse_stb(3);
        check_now("R7", 11'h4C3);
        check_now("R8", 11'h4C3);

        // R4: the take falls on the first serial cycle and is kept
        @(negedge clk); #1 mode_par = 1'b1; code_pins = 11'h0F0;
        shift_bits(16'h0333, 11);
        pulse_stb(2);
        check_now("R4", 11'h333);

        // R10: strobe already high across reset release
        @(negedge clk); #1 rst_n = 1'b0; latch_stb = 1'b1;
        shift_bits(16'h0444, 11);
        exp_hold = shadow;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check_now("R10", 11'd0);
        #1 latch_stb = 1'b0;
        repeat (5) @(negedge clk);
        check_now("R10", 11'd0);
        load_serial(11'h555);
        check_now("R4", 11'h555);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule